// File: doc/BRIEF.md
# Memory-to-Link Frame Transmit DMA

This block moves one outgoing frame from system memory to a serial-storage link layer. A single-cycle start command supplies a base address, a payload length in 32-bit words and a frame-type select. The block then reads memory through an AXI4 read master with a 256-bit data bus. It uses fixed 16-beat incrementing bursts of 512 bytes, and it keeps at most one burst in flight. The beats land in a width-converting FIFO, and the FIFO is unloaded as 32-bit words over a valid/ready stream that marks the final word of the frame.

When a data frame is selected, the block sends a fixed header word before the payload. A request state machine throttles new bursts so that the FIFO can always absorb a complete burst. Words that the last burst fetched beyond the programmed length are dropped. A one-cycle completion pulse ends the transfer. A sticky flag records any read response that was not OKAY.

Top module: `frameTxDma`

## Requirements
- R1: While reset is asserted and after it is released, `arValid`, `txValid`, `busy`, `done` and `error` are low.
- R2: Every read request has `arLen`=15, `arSize`=5 (32 bytes) and `arBurst`=2'b01 (incrementing). The k-th request of a frame (k from 0) carries address base+512·k. A frame issues ceil(wordCount/128) requests, and `arAddr` stays stable while `arValid` waits for `arReady`.
- R3: At most one burst is outstanding (`arValid` is never high while `rReady` is high). A new burst is requested only when the FIFO of DEPTH beats (32 by default) holds at most DEPTH−16 beats. With the link stalled, a long frame therefore issues exactly two requests.
- R4: Each 256-bit beat is sent as eight 32-bit words, bits [31:0] first and bits [255:224] last. Payload word i of a frame is the 32-bit word at byte address base+4·i.
- R5: With `isDataFrame`=1 the first word of the frame is the header 0x00000046, followed by the payload. With `isDataFrame`=0 no header is sent.
- R6: Exactly `wordCount` payload words are sent. `txLast` is high only on the final word of the frame. Words fetched beyond the count are discarded, and the next frame starts from its own data.
- R7: While `txValid` is high and `txReady` is low, `txValid` stays high and `txData` is unchanged.
- R8: `busy` rises the cycle after an accepted start. `done` is a one-cycle pulse with `busy` low, raised after the last word is accepted and every burst has returned. A start while busy has no effect on the frame in progress.
- R9: A read beat with `rResp`≠0 sets `error`. The flag holds until the next accepted start clears it, and the beat's data is still forwarded.
- R10: A zero `wordCount` issues no read. A data frame then sends only the header, with `txLast` high. A non-data frame sends nothing and only pulses `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| baseAddr | input | 32 | Frame payload byte address, 512-byte aligned |
| wordCount | input | 16 | Payload length in 32-bit words |
| isDataFrame | input | 1 | 1: prepend data-frame header |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Sticky non-OKAY read response flag |
| arAddr | output | 32 | Read burst address |
| arLen | output | 8 | Burst length minus one |
| arSize | output | 3 | Beat size code |
| arBurst | output | 2 | Burst type |
| arValid | output | 1 | Read request valid |
| arReady | input | 1 | Read request accepted |
| rData | input | 256 | Read beat data |
| rResp | input | 2 | Read beat response |
| rLast | input | 1 | Final beat of burst |
| rValid | input | 1 | Read beat valid |
| rReady | output | 1 | Read beat accepted |
| txData | output | 32 | Link word |
| txValid | output | 1 | Link word valid |
| txLast | output | 1 | Final word of frame |
| txReady | input | 1 | Link accepts word |

## Verification
Two functions often fall in the same cycle. One is the push of a returning read beat into the FIFO, and the other is the pop of a word that finishes the head beat. Both move the occupancy count, and the burst throttle decides from that count. The bench provokes this overlap with random gaps on `rValid` and `arReady`, played against constant, alternating and random `txReady` patterns, over a sweep of lengths around beat and burst boundaries. Every word is judged against an arithmetic memory image. A stalled-link run checks that exactly two requests go out, and the next frame's first words show that the discard of surplus beats at frame end left no stale data.

// File: rtl/frameTxPkg.sv
package frameTxPkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic push;      // accept the current read beat into the FIFO
    logic advance;   // a payload word was taken by the link
    logic lastWord;  // the word being taken is the final payload word
    logic flush;     // drop whatever is left in the FIFO
    logic hdrSel;    // present the header word instead of FIFO data
  } pathStrobes_t;

  localparam logic [31:0] DATA_FRAME_HDR = 32'h0000_0046;

endpackage

// File: rtl/txDmaPath.sv
module txDmaPath
  import frameTxPkg::*;
#(
  parameter int MEM_W  = 256,
  parameter int LINK_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pathStrobes_t               strobes,
  input  logic [MEM_W-1:0]           rData,
  output logic                       fifoEmpty,
  output logic [$clog2(DEPTH):0]     fifoCount,
  output logic [LINK_W-1:0]          txData
);

  localparam int WORDS_PER_BEAT = MEM_W / LINK_W;
  localparam int SEL_W          = $clog2(WORDS_PER_BEAT);
  localparam int PTR_W          = $clog2(DEPTH);
  localparam int FC_W           = PTR_W + 1;

  logic [MEM_W-1:0]  beatStore [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [FC_W-1:0]   count;
  logic [SEL_W-1:0]  wordSel;
  logic [MEM_W-1:0]  headBeat;
  logic [LINK_W-1:0] headWords [WORDS_PER_BEAT];
  logic              pop;

  assign headBeat = beatStore[rdPtr];

  // Split the head beat into link words, least significant first
  for (genvar g = 0; g < WORDS_PER_BEAT; g++) begin : gSplit
    assign headWords[g] = headBeat[g*LINK_W +: LINK_W];
  end

  assign pop = strobes.advance &&
               ((wordSel == SEL_W'(WORDS_PER_BEAT - 1)) || strobes.lastWord);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push) beatStore[wrPtr] <= rData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      wordSel <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (pop) begin
        rdPtr   <= nextPtr(rdPtr);
        wordSel <= '0;
      end else if (strobes.advance) begin
        wordSel <= wordSel + 1'b1;
      end
      case ({strobes.push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign fifoEmpty = (count == '0);
  assign fifoCount = count;
  assign txData    = strobes.hdrSel ? DATA_FRAME_HDR[LINK_W-1:0] : headWords[wordSel];

endmodule

// File: rtl/txDmaCtrl.sv
module txDmaCtrl
  import frameTxPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int MEM_W     = 256,
  parameter int LINK_W    = 32,
  parameter int BURST_LEN = 16,
  parameter int DEPTH     = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      baseAddr,
  input  logic [CNT_W-1:0]       wordCount,
  input  logic                   isDataFrame,
  output logic                   busy,
  output logic                   done,
  output logic                   error,
  output logic [ADDR_W-1:0]      arAddr,
  output logic                   arValid,
  input  logic                   arReady,
  input  logic [1:0]             rResp,
  input  logic                   rLast,
  input  logic                   rValid,
  output logic                   rReady,
  output logic                   txValid,
  output logic                   txLast,
  input  logic                   txReady,
  input  logic                   fifoEmpty,
  input  logic [$clog2(DEPTH):0] fifoCount,
  output pathStrobes_t           strobes
);

  localparam int WORDS_PER_BEAT  = MEM_W / LINK_W;
  localparam int WORDS_PER_BURST = WORDS_PER_BEAT * BURST_LEN;
  localparam int WPB_LOG         = $clog2(WORDS_PER_BURST);
  localparam int NB_W            = CNT_W + 1 - WPB_LOG;
  localparam int BURST_BYTES     = BURST_LEN * MEM_W / 8;
  localparam int FC_W            = $clog2(DEPTH) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_HEAD, ST_PAYLOAD, ST_DRAIN} ctrlState_t;

  ctrlState_t        state;
  logic [CNT_W-1:0]  wordsLeft;
  logic [NB_W-1:0]   burstsLeft;
  logic [NB_W-1:0]   burstsNeeded;
  logic [CNT_W:0]    roundUp;
  logic [ADDR_W-1:0] nextAddr;
  logic              arValidQ, burstActive, doneQ, errorQ;
  logic              rHs, arHs, roomForBurst, issueOk, wordTaken, drainDone;

  assign roundUp      = {1'b0, wordCount} + (CNT_W+1)'(WORDS_PER_BURST - 1);
  assign burstsNeeded = roundUp[CNT_W:WPB_LOG];

  assign rReady       = burstActive;
  assign rHs          = rValid && burstActive;
  assign arHs         = arValidQ && arReady;
  assign roomForBurst = fifoCount <= FC_W'(DEPTH - BURST_LEN);
  assign issueOk      = (state != ST_IDLE) && !arValidQ && !burstActive &&
                        (burstsLeft != '0) && roomForBurst;

  always_comb begin
    txValid = 1'b0;
    txLast  = 1'b0;
    case (state)
      ST_HEAD: begin
        txValid = 1'b1;
        txLast  = (wordsLeft == '0);
      end
      ST_PAYLOAD: begin
        txValid = !fifoEmpty;
        txLast  = !fifoEmpty && (wordsLeft == CNT_W'(1));
      end
      default: ;
    endcase
  end

  assign wordTaken = txValid && txReady;
  assign drainDone = (state == ST_DRAIN) && (burstsLeft == '0) &&
                     !burstActive && !arValidQ;

  always_comb begin
    strobes          = '0;
    strobes.push     = rHs;
    strobes.advance  = (state == ST_PAYLOAD) && wordTaken;
    strobes.lastWord = (wordsLeft == CNT_W'(1));
    strobes.flush    = drainDone;
    strobes.hdrSel   = (state == ST_HEAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      wordsLeft   <= '0;
      burstsLeft  <= '0;
      nextAddr    <= '0;
      arValidQ    <= 1'b0;
      burstActive <= 1'b0;
      doneQ       <= 1'b0;
      errorQ      <= 1'b0;
    end else begin
      doneQ <= drainDone;

      // Burst request issue and completion
      if (arHs) begin
        arValidQ    <= 1'b0;
        burstActive <= 1'b1;
        burstsLeft  <= burstsLeft - 1'b1;
        nextAddr    <= nextAddr + ADDR_W'(BURST_BYTES);
      end else if (issueOk) begin
        arValidQ <= 1'b1;
      end
      if (rHs) begin
        if (rResp != 2'b00) errorQ <= 1'b1;
        if (rLast) burstActive <= 1'b0;
      end

      // Frame sequencing
      case (state)
        ST_IDLE: if (start) begin
          wordsLeft  <= wordCount;
          burstsLeft <= burstsNeeded;
          nextAddr   <= baseAddr;
          errorQ     <= 1'b0;
          if (isDataFrame)            state <= ST_HEAD;
          else if (wordCount == '0)   state <= ST_DRAIN;
          else                        state <= ST_PAYLOAD;
        end
        ST_HEAD: if (wordTaken) begin
          state <= (wordsLeft == '0) ? ST_DRAIN : ST_PAYLOAD;
        end
        ST_PAYLOAD: if (wordTaken) begin
          wordsLeft <= wordsLeft - 1'b1;
          if (wordsLeft == CNT_W'(1)) state <= ST_DRAIN;
        end
        ST_DRAIN: if (drainDone) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign arAddr  = nextAddr;
  assign arValid = arValidQ;
  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;
  assign error   = errorQ;

endmodule

// File: rtl/frameTxDma.sv
module frameTxDma
  import frameTxPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int MEM_W     = 256,
  parameter int LINK_W    = 32,
  parameter int BURST_LEN = 16,
  parameter int DEPTH     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              isDataFrame,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] arAddr,
  output logic [7:0]        arLen,
  output logic [2:0]        arSize,
  output logic [1:0]        arBurst,
  output logic              arValid,
  input  logic              arReady,
  input  logic [MEM_W-1:0]  rData,
  input  logic [1:0]        rResp,
  input  logic              rLast,
  input  logic              rValid,
  output logic              rReady,
  output logic [LINK_W-1:0] txData,
  output logic              txValid,
  output logic              txLast,
  input  logic              txReady
);

  localparam int FC_W = $clog2(DEPTH) + 1;

  pathStrobes_t    strobes;
  logic            fifoEmpty;
  logic [FC_W-1:0] fifoCount;

  assign arLen   = 8'(BURST_LEN - 1);
  assign arSize  = 3'($clog2(MEM_W / 8));
  assign arBurst = 2'b01;

  txDmaCtrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MEM_W(MEM_W), .LINK_W(LINK_W),
    .BURST_LEN(BURST_LEN), .DEPTH(DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .wordCount(wordCount), .isDataFrame(isDataFrame),
    .busy(busy), .done(done), .error(error),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rResp(rResp), .rLast(rLast), .rValid(rValid), .rReady(rReady),
    .txValid(txValid), .txLast(txLast), .txReady(txReady),
    .fifoEmpty(fifoEmpty), .fifoCount(fifoCount), .strobes(strobes)
  );

  txDmaPath #(
    .MEM_W(MEM_W), .LINK_W(LINK_W), .DEPTH(DEPTH)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rData(rData),
    .fifoEmpty(fifoEmpty), .fifoCount(fifoCount), .txData(txData)
  );

endmodule

// File: rtl/frameTxDmaChecker.sv
module frameTxDmaChecker #(
  parameter int ADDR_W    = 32,
  parameter int LINK_W    = 32,
  parameter int BURST_LEN = 16,
  parameter int DEPTH     = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   arValid,
  input logic                   arReady,
  input logic [ADDR_W-1:0]      arAddr,
  input logic                   rValid,
  input logic                   rReady,
  input logic                   txValid,
  input logic                   txReady,
  input logic [LINK_W-1:0]      txData,
  input logic                   busy,
  input logic                   done,
  input logic                   error,
  input logic [$clog2(DEPTH):0] fifoCount
);

  localparam int FC_W = $clog2(DEPTH) + 1;

  assert_ar_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !arReady |=> arValid && $stable(arAddr));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    rValid && rReady |-> fifoCount < FC_W'(DEPTH));

  assert_room_on_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> fifoCount <= FC_W'(DEPTH - BURST_LEN));

  assert_single_burst_R3: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> !rReady);

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_error_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !error);

endmodule

bind frameTxDma frameTxDmaChecker #(
  .ADDR_W(ADDR_W), .LINK_W(LINK_W), .BURST_LEN(BURST_LEN), .DEPTH(DEPTH)
) u_check (
  .clk(clk), .rstN(rstN), .arValid(arValid), .arReady(arReady), .arAddr(arAddr),
  .rValid(rValid), .rReady(rReady), .txValid(txValid), .txReady(txReady),
  .txData(txData), .busy(busy), .done(done), .error(error), .fifoCount(fifoCount)
);

// File: tb/test_frameTxDma.sv
`timescale 1ns/1ps
module test_frameTxDma;

  logic         clk = 1'b0;
  logic         rstN;
  logic         start;
  logic [31:0]  baseAddr;
  logic [15:0]  wordCount;
  logic         isDataFrame;
  logic         busy, done, error;
  logic [31:0]  arAddr;
  logic [7:0]   arLen;
  logic [2:0]   arSize;
  logic [1:0]   arBurst;
  logic         arValid, arReady;
  logic [255:0] rData;
  logic [1:0]   rResp;
  logic         rLast, rValid, rReady;
  logic [31:0]  txData;
  logic         txValid, txLast, txReady;

  always #2 clk = ~clk;  // 250 MHz

  frameTxDma i_frameTxDma (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .wordCount(wordCount), .isDataFrame(isDataFrame),
    .busy(busy), .done(done), .error(error),
    .arAddr(arAddr), .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
    .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rLast(rLast), .rValid(rValid), .rReady(rReady),
    .txData(txData), .txValid(txValid), .txLast(txLast), .txReady(txReady)
  );

  int          checks = 0;
  int          fails  = 0;
  logic [31:0] expQ[$];
  int          rxIdx = 0;
  logic [31:0] expArAddr = '0;
  int          arCount = 0;
  int          readyMode = 0;
  int          holdCnt = 0;
  bit          injectErr = 1'b0;
  bit          prevHold = 1'b0;
  logic [31:0] prevData = '0;

  function automatic logic [31:0] memW(input logic [31:0] idx);
    return (idx * 32'h0100_0193) ^ 32'hC3A5_0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory responder: one burst at a time, random gaps
  initial begin
    logic [15:0] lf;
    bit          active;
    logic [31:0] cur;
    int          beat;
    bit          arHsS, rHsS;
    logic [31:0] arAddrS;
    lf = 16'hACE1; active = 0; cur = '0; beat = 0;
    arReady = 0; rValid = 0; rData = '0; rResp = 0; rLast = 0;
    forever begin
      @(negedge clk);
      arHsS = arValid && arReady;
      rHsS  = rValid && rReady;
      arAddrS = arAddr;
      @(posedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (!rstN) begin
        active = 0; rValid = 0; arReady = 0;
      end else begin
        if (rHsS) begin beat++; if (beat == 16) active = 0; end
        if (arHsS) begin active = 1; cur = arAddrS; beat = 0; end
        arReady = lf[2] | lf[5];
        rValid  = active && ((rValid && !rHsS) || lf[0] || lf[1]);
        rLast   = (beat == 15);
        for (int k = 0; k < 8; k++)
          rData[k*32 +: 32] = memW((cur >> 2) + 32'(beat * 8 + k));
        rResp = injectErr ? 2'b10 : 2'b00;
      end
    end
  end

  // Link ready patterns
  initial begin
    logic [15:0] lf;
    lf = 16'h1D2B;
    txReady = 0;
    forever begin
      @(posedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (readyMode)
        0: txReady = 1'b1;
        1: txReady = !txReady;
        2: txReady = (lf[3] & lf[7]) | lf[1];
        default: begin
          if (holdCnt > 0) begin holdCnt--; txReady = 1'b0; end
          else txReady = 1'b1;
        end
      endcase
    end
  end

  // Output monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (prevHold)
        check(txValid && txData == prevData, "R7 hold", {31'd0, txValid, txData}, {32'd1, prevData});
      prevHold = txValid && !txReady;
      prevData = txData;
      if (txValid && txReady) begin
        if (rxIdx >= expQ.size()) begin
          check(1'b0, "R6 extra word", 64'(rxIdx), 64'(expQ.size()));
        end else begin
          check(txData == expQ[rxIdx], "R4/R5 word", 64'(txData), 64'(expQ[rxIdx]));
          check(txLast == (rxIdx == expQ.size() - 1), "R6 last", 64'(txLast), 64'(rxIdx == expQ.size() - 1));
        end
        rxIdx++;
      end
      if (arValid && arReady) begin
        check(arAddr == expArAddr && arLen == 8'd15 && arSize == 3'd5 && arBurst == 2'b01,
              "R2 request", {arAddr, 19'd0, arLen, arSize, arBurst}, {expArAddr, 19'd0, 8'd15, 3'd5, 2'b01});
        expArAddr += 32'd512;
        arCount++;
      end
    end
  end

  task automatic runFrame(input logic [31:0] base, input int cnt, input bit isData,
                          input int mode, input bit err, input bit throttle, input bit midStart);
    int t;
    expQ.delete();
    if (isData) expQ.push_back(32'h0000_0046);
    for (int i = 0; i < cnt; i++) expQ.push_back(memW((base >> 2) + 32'(i)));
    rxIdx = 0; expArAddr = base; arCount = 0;
    injectErr = err;
    if (throttle) holdCnt = 300;
    readyMode = mode;
    @(posedge clk); #1;
    baseAddr = base; wordCount = 16'(cnt); isDataFrame = isData; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R8 busy", 64'(busy), 64'd1);
    check(error == 1'b0, "R9 cleared", 64'(error), 64'd0);
    if (midStart) begin
      repeat (4) @(posedge clk);
      #1; baseAddr = 32'h0800_0000; wordCount = 16'd3; isDataFrame = !isData; start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
    end
    if (throttle) begin
      repeat (250) @(negedge clk);
      check(arCount == 2, "R3 throttle", 64'(arCount), 64'd2);
    end
    t = 0;
    while (t < 20000) begin
      @(negedge clk);
      if (done) break;
      t++;
    end
    check(done == 1'b1 && busy == 1'b0, "R8 done", {62'd0, done, busy}, 64'd2);
    check(rxIdx == expQ.size(), "R6 count", 64'(rxIdx), 64'(expQ.size()));
    check(arCount == (cnt + 127) / 128, "R2 bursts", 64'(arCount), 64'((cnt + 127) / 128));
    check(error == err, "R9 error", 64'(error), 64'(err));
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8 pulse", {62'd0, done, busy}, 64'd0);
    injectErr = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lens[10] = '{0, 1, 7, 8, 9, 127, 128, 129, 255, 300};
    int k;
    rstN = 1'b0; start = 1'b0; baseAddr = '0; wordCount = '0; isDataFrame = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!arValid && !txValid && !busy && !done && !error, "R1 in reset",
          {59'd0, arValid, txValid, busy, done, error}, 64'd0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check(!arValid && !txValid && !busy && !done && !error, "R1 after reset",
          {59'd0, arValid, txValid, busy, done, error}, 64'd0);

    // Sweep lengths x frame type x ready pattern (R4 R5 R6 R10)
    k = 0;
    for (int m = 0; m < 3; m++)
      for (int d = 0; d < 2; d++)
        for (int n = 0; n < 10; n++) begin
          runFrame(32'h0001_0000 + 32'(k) * 32'h0000_2000, lens[n], bit'(d), m, 1'b0, 1'b0, 1'b0);
          k++;
        end

    // Throttle with stalled link (R3)
    runFrame(32'h0040_0000, 1000, 1'b1, 3, 1'b0, 1'b1, 1'b0);
    // Start while busy ignored (R8)
    runFrame(32'h0050_0000, 200, 1'b1, 2, 1'b0, 1'b0, 1'b1);
    // Error response then clear (R9)
    runFrame(32'h0060_0000, 40, 1'b1, 0, 1'b1, 1'b0, 1'b0);
    runFrame(32'h0060_2000, 9, 1'b0, 1, 1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule